// File: doc/BRIEF.md
# Flash Command Interface State Machine

This block is the command front end of a byte-wide NOR flash array that sits behind an asynchronous SRAM-style bus, with chip enable, output enable, write enable, an address and a split data bus (input, output and output enable for an external tri-state pad). All bus pins are sampled in one clock domain. A write cycle ends on the rising edge of the combined write strobe, which is chip enable OR write enable (both active low). The address is captured when that strobe falls, and the data is taken when it rises. The strobe can therefore be driven by write enable with chip enable held low, or by chip enable with write enable held low.

A host runs unlock sequences to pick one of three modes. Read mode returns array contents. Identifier mode returns two fixed code bytes. Program mode starts an embedded engine. The engine can only clear bits in a small internal byte array, and it applies clock-timed pulses until the stored byte matches the request or a pulse limit runs out. While the engine works, reads return a status byte that a host can poll. A low-voltage-detect input aborts any activity.

Top module: `flash_cmd_if`

## Requirements
- R1: After reset the block is in read mode. Every array byte reads 0xFF, and dq_oe is 0 while ce_n or oe_n is high.
- R2: dq_oe is 1 in the same cycle that ce_n and oe_n are both low, and 0 at any other time, including standby with ce_n high.
- R3: The write strobe is ce_n OR we_n. It is only taken when oe_n is high. The address is captured at the strobe's falling edge and the data at its rising edge, and this works for both we_n-controlled and ce_n-controlled cycles.
- R4: The writes 0xAA at 0x555, 0x55 at 0x2AA and 0xA0 at 0x555, followed by a fourth write, start a program of that write's data at that write's address. Only address bits [10:0] are compared.
- R5: A program stores the old byte AND the new byte. It stays busy for PULSE_CYC cycles when no bit must rise, then returns to read mode by itself.
- R6: The writes 0xAA at 0x555, 0x55 at 0x2AA and 0x90 at 0x555 enter identifier mode. In this mode, address bits [7:0] equal to 0x00 read 0x01, equal to 0x01 read 0xA4, and any other value reads 0x00. The upper address bits are ignored, and the mode lasts across reads until a new command is written.
- R7: A write of 0xF0 to any address returns the block to read mode. A write whose address or data does not fit the current step of a sequence also returns it to read mode and discards the partial sequence.
- R8: Every write cycle is ignored while a program is busy, including unlock steps.
- R9: While a program is busy, every read returns a status byte regardless of address. Bit 7 is the complement of bit 7 of the target data, bit 6 inverts after each completed read, and bits 5 to 0 are 0. Bit 6 is 0 when the program starts.
- R10: If a program asks a 0 bit to become 1, the engine gives up after PULSE_CYC*PULSE_MAX cycles. The status byte then has bit 5 set, and the block keeps returning status until any write, which returns it to read mode with the ANDed byte stored.
- R11: A high lvd_i at a clock edge aborts a running program and clears the failure flag, identifier mode and any partial sequence, leaving read mode.
- R12: A program keeps running to completion while the device is deselected (ce_n high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples all bus pins |
| rst_n | input | 1 | Synchronous active-low reset |
| lvd_i | input | 1 | Low-voltage detect, active high |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| dq_i | input | 8 | Data from the bus pads |
| dq_o | output | 8 | Data to the bus pads |
| dq_oe | output | 1 | Pad output enable |

## Verification
The dq_oe and dq_o outputs depend combinationally on the pins and on the state, so a read shows its value in the same cycle that the strobes are asserted. A command takes effect at the first clock edge that sees the write strobe high after it was low, so the new mode appears from the next cycle on. A successful program leaves status mode PULSE_CYC edges after its start edge, and a failing one raises bit 5 after PULSE_CYC*PULSE_MAX edges. The bench changes pins one nanosecond after a rising edge and compares at the falling edge, against a behavioural model that counts down the same windows, so every sample lands after the edge that produced the value being checked.

// File: rtl/flash_cmd_pkg.sv
// Package: constants shared by the flash command front end.
// Assumes command matching uses address bits [10:0] only.
package flash_cmd_pkg;

    localparam int CMD_AW = 11;

    localparam logic [CMD_AW-1:0] KEY_ADDR_A = 11'h555;
    localparam logic [CMD_AW-1:0] KEY_ADDR_B = 11'h2AA;

    localparam logic [7:0] KEY_DATA_A = 8'hAA;
    localparam logic [7:0] KEY_DATA_B = 8'h55;
    localparam logic [7:0] OPC_PROG   = 8'hA0;
    localparam logic [7:0] OPC_IDENT  = 8'h90;
    localparam logic [7:0] OPC_RESET  = 8'hF0;

    localparam logic [7:0] IDENT_LO   = 8'h01;
    localparam logic [7:0] IDENT_HI   = 8'hA4;

    // Unlock progress of the command sequencer
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_KEY1  = 2'd1,
        SEQ_KEY2  = 2'd2,
        SEQ_PSET  = 2'd3
    } seq_e;

endpackage

// File: rtl/fcs_bus_edge.sv
// Module: fcs_bus_edge
// Finds the ends of bus write and read cycles. The write strobe is
// ce_n|we_n: its falling edge captures the address and its rising edge,
// with oe_n high, yields a one-cycle write event that carries the data on
// dq_i at that moment. The read strobe is ce_n|oe_n, and its rising edge
// marks a completed read. Assumes the pins are already synchronous to clk.
module fcs_bus_edge #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        dq_i,
    output logic              wr_evt,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              rd_done
);

    logic              wstb_now;
    logic              rstb_now;
    logic              wstb_q;
    logic              rstb_q;
    logic [ADDR_W-1:0] addr_lat;

    assign wstb_now = ce_n | we_n;
    assign rstb_now = ce_n | oe_n;

    // Remember strobe levels and capture the address at a write-strobe fall
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wstb_q   <= 1'b1;
            rstb_q   <= 1'b1;
            addr_lat <= '0;
        end else begin
            wstb_q <= wstb_now;
            rstb_q <= rstb_now;
            if (!wstb_now && wstb_q) begin
                addr_lat <= addr;
            end
        end
    end

    assign wr_evt  = wstb_now && !wstb_q && oe_n;
    assign wr_addr = addr_lat;
    assign wr_data = dq_i;
    assign rd_done = rstb_now && !rstb_q;

endmodule

// File: rtl/fcs_seq_decode.sv
// Module: fcs_seq_decode
// Command sequencer. Follows the two unlock writes and the opcode write,
// and keeps the identifier-mode flag. It issues a one-cycle start for the
// program target write and a clear for a latched failure. Assumes the
// engine's busy and fail flags are registered, so that they reflect the
// state before the current edge.
module fcs_seq_decode
    import flash_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lvd_i,
    input  logic              wr_evt,
    input  logic [CMD_AW-1:0] cmd_addr,
    input  logic [7:0]        wr_data,
    input  logic              busy,
    input  logic              fail,
    output logic              start,
    output logic              clr_fail,
    output logic              id_mode
);

    seq_e seq_q;
    seq_e seq_d;
    logic id_q;
    logic id_d;

    // Next-state decode for one write event
    always_comb begin
        seq_d    = seq_q;
        id_d     = id_q;
        start    = 1'b0;
        clr_fail = 1'b0;
        if (lvd_i) begin
            seq_d = SEQ_IDLE;
            id_d  = 1'b0;
        end else if (wr_evt && fail) begin
            clr_fail = 1'b1;
            seq_d    = SEQ_IDLE;
            id_d     = 1'b0;
        end else if (wr_evt && !busy) begin
            if (wr_data == OPC_RESET) begin
                seq_d = SEQ_IDLE;
                id_d  = 1'b0;
            end else begin
                case (seq_q)
                    SEQ_IDLE: begin
                        if (cmd_addr == KEY_ADDR_A && wr_data == KEY_DATA_A) begin
                            seq_d = SEQ_KEY1;
                        end else begin
                            id_d = 1'b0;
                        end
                    end
                    SEQ_KEY1: begin
                        if (cmd_addr == KEY_ADDR_B && wr_data == KEY_DATA_B) begin
                            seq_d = SEQ_KEY2;
                        end else begin
                            seq_d = SEQ_IDLE;
                            id_d  = 1'b0;
                        end
                    end
                    SEQ_KEY2: begin
                        seq_d = SEQ_IDLE;
                        if (cmd_addr == KEY_ADDR_A && wr_data == OPC_PROG) begin
                            seq_d = SEQ_PSET;
                        end else if (cmd_addr == KEY_ADDR_A && wr_data == OPC_IDENT) begin
                            id_d = 1'b1;
                        end else begin
                            id_d = 1'b0;
                        end
                    end
                    default: begin
                        start = 1'b1;
                        seq_d = SEQ_IDLE;
                        id_d  = 1'b0;
                    end
                endcase
            end
        end
    end

    // Sequencer and mode registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q <= SEQ_IDLE;
            id_q  <= 1'b0;
        end else begin
            seq_q <= seq_d;
            id_q  <= id_d;
        end
    end

    assign id_mode = id_q;

endmodule

// File: rtl/fcs_prog_engine.sv
// Module: fcs_prog_engine
// Embedded program engine and byte array. Each pulse lasts PULSE_CYC
// cycles. At the end of a pulse the target byte becomes old AND new, and
// the engine stops once the stored byte equals the request. If it still
// differs after PULSE_MAX pulses, the engine stops with a held failure
// flag. It also builds the status byte, whose toggle bit inverts on every
// completed read while the engine is busy or failed. Assumes start is
// never raised while busy or fail is high.
module fcs_prog_engine #(
    parameter int ADDR_W    = 11,
    parameter int PULSE_CYC = 8,
    parameter int PULSE_MAX = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [7:0]        start_data,
    input  logic              clr_fail,
    input  logic              rd_done,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              busy,
    output logic              fail,
    output logic [7:0]        array_byte,
    output logic [7:0]        status_byte
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int CYC_W = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;
    localparam int PLS_W = (PULSE_MAX > 1) ? $clog2(PULSE_MAX) : 1;
    localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(PULSE_CYC - 1);
    localparam logic [PLS_W-1:0] PLS_LAST = PLS_W'(PULSE_MAX - 1);

    logic [7:0]        mem [DEPTH];
    logic              busy_q;
    logic              fail_q;
    logic              tog_q;
    logic [ADDR_W-1:0] tgt_a;
    logic [7:0]        tgt_d;
    logic [CYC_W-1:0]  cyc_q;
    logic [PLS_W-1:0]  pls_q;
    logic              pulse_now;
    logic [7:0]        merged;
    logic              verify_ok;

    assign pulse_now = busy_q && (cyc_q == CYC_LAST);
    assign merged    = mem[tgt_a] & tgt_d;
    assign verify_ok = (merged == tgt_d);

    // Engine control: start, pulse timing, verify, limit and toggle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            fail_q <= 1'b0;
            tog_q  <= 1'b0;
            tgt_a  <= '0;
            tgt_d  <= '0;
            cyc_q  <= '0;
            pls_q  <= '0;
        end else if (abort) begin
            busy_q <= 1'b0;
            fail_q <= 1'b0;
            cyc_q  <= '0;
            pls_q  <= '0;
        end else begin
            if (clr_fail) begin
                fail_q <= 1'b0;
            end
            if (start) begin
                busy_q <= 1'b1;
                tgt_a  <= start_addr;
                tgt_d  <= start_data;
                cyc_q  <= '0;
                pls_q  <= '0;
                tog_q  <= 1'b0;
            end else begin
                if (pulse_now) begin
                    cyc_q <= '0;
                    if (verify_ok) begin
                        busy_q <= 1'b0;
                    end else if (pls_q == PLS_LAST) begin
                        busy_q <= 1'b0;
                        fail_q <= 1'b1;
                    end else begin
                        pls_q <= pls_q + 1'b1;
                    end
                end else if (busy_q) begin
                    cyc_q <= cyc_q + 1'b1;
                end
                if ((busy_q || fail_q) && rd_done) begin
                    tog_q <= ~tog_q;
                end
            end
        end
    end

    // Byte array: erased on reset, ANDed at the end of each pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= 8'hFF;
            end
        end else if (pulse_now && !abort) begin
            mem[tgt_a] <= merged;
        end
    end

    assign busy        = busy_q;
    assign fail        = fail_q;
    assign array_byte  = mem[rd_addr];
    assign status_byte = {~tgt_d[7], tog_q, fail_q, 5'b0_0000};

endmodule

// File: rtl/flash_cmd_if.sv
// Module: flash_cmd_if (top)
// Command front end of a byte-wide NOR flash array. It joins the bus edge
// finder, the command sequencer and the program engine, and chooses the
// byte driven on a read: status while busy or failed, the identifier
// codes in identifier mode, and array data otherwise. The pad output
// enable follows ce_n and oe_n directly. Assumes ADDR_W >= 11.
module flash_cmd_if
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int PULSE_CYC = 8,
    parameter int PULSE_MAX = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lvd_i,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        dq_i,
    output logic [7:0]        dq_o,
    output logic              dq_oe
);

    logic              wr_evt;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data;
    logic              rd_done;
    logic              prog_start;
    logic              clr_fail;
    logic              id_mode;
    logic              eng_busy;
    logic              eng_fail;
    logic [7:0]        array_byte;
    logic [7:0]        status_byte;
    logic [7:0]        id_byte;

    fcs_bus_edge #(.ADDR_W(ADDR_W)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_n    (ce_n),
        .oe_n    (oe_n),
        .we_n    (we_n),
        .addr    (addr),
        .dq_i    (dq_i),
        .wr_evt  (wr_evt),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_done (rd_done)
    );

    fcs_seq_decode u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvd_i    (lvd_i),
        .wr_evt   (wr_evt),
        .cmd_addr (wr_addr[CMD_AW-1:0]),
        .wr_data  (wr_data),
        .busy     (eng_busy),
        .fail     (eng_fail),
        .start    (prog_start),
        .clr_fail (clr_fail),
        .id_mode  (id_mode)
    );

    fcs_prog_engine #(
        .ADDR_W    (ADDR_W),
        .PULSE_CYC (PULSE_CYC),
        .PULSE_MAX (PULSE_MAX)
    ) u_eng (
        .clk         (clk),
        .rst_n       (rst_n),
        .abort       (lvd_i),
        .start       (prog_start),
        .start_addr  (wr_addr),
        .start_data  (wr_data),
        .clr_fail    (clr_fail),
        .rd_done     (rd_done),
        .rd_addr     (addr),
        .busy        (eng_busy),
        .fail        (eng_fail),
        .array_byte  (array_byte),
        .status_byte (status_byte)
    );

    // Identifier code chosen by the low address byte
    always_comb begin
        case (addr[7:0])
            8'h00:   id_byte = IDENT_LO;
            8'h01:   id_byte = IDENT_HI;
            default: id_byte = 8'h00;
        endcase
    end

    // Read data source by mode priority
    always_comb begin
        if (eng_busy || eng_fail) begin
            dq_o = status_byte;
        end else if (id_mode) begin
            dq_o = id_byte;
        end else begin
            dq_o = array_byte;
        end
    end

    assign dq_oe = !ce_n && !oe_n;

endmodule

// File: rtl/flash_cmd_if_chk.sv
// Module: flash_cmd_if_chk
// Assertion checker attached to flash_cmd_if with a bind. It watches pad
// behaviour, engine flags, sequencer outputs and the length of each busy
// period, which it measures with its own counter.
module flash_cmd_if_chk #(
    parameter int PULSE_CYC = 8,
    parameter int PULSE_MAX = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lvd_i,
    input  logic       ce_n,
    input  logic       oe_n,
    input  logic [7:0] addr_lo,
    input  logic [7:0] dq_o,
    input  logic       dq_oe,
    input  logic       busy,
    input  logic       fail,
    input  logic       start,
    input  logic       id_mode
);

    localparam int BUSY_LIMIT = PULSE_CYC * PULSE_MAX;

    int busy_run;

    // Count consecutive busy cycles
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) begin
            busy_run <= 0;
        end else begin
            busy_run <= busy_run + 1;
        end
    end

    AST_PAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || oe_n) |-> !dq_oe); // R2

    AST_START_TO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !lvd_i) |=> busy); // R4

    AST_BUSY_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start); // R8

    AST_BUSY_DQ5_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && dq_oe) |-> !dq_o[5]); // R9

    AST_FAIL_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail) |-> $past(busy)); // R10

    AST_FAIL_DQ5_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && dq_oe) |-> dq_o[5]); // R10

    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= BUSY_LIMIT); // R10

    AST_ID_CODE_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (id_mode && !busy && !fail && dq_oe && addr_lo == 8'h00) |-> dq_o == 8'h01); // R6

    AST_LVD_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        lvd_i |=> (!busy && !fail && !id_mode)); // R11

endmodule

bind flash_cmd_if flash_cmd_if_chk #(
    .PULSE_CYC (PULSE_CYC),
    .PULSE_MAX (PULSE_MAX)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .lvd_i   (lvd_i),
    .ce_n    (ce_n),
    .oe_n    (oe_n),
    .addr_lo (addr[7:0]),
    .dq_o    (dq_o),
    .dq_oe   (dq_oe),
    .busy    (eng_busy),
    .fail    (eng_fail),
    .start   (prog_start),
    .id_mode (id_mode)
);

// File: tb/flash_cmd_if_bench.sv
// Bench for flash_cmd_if. It drives pins 1 ns after each rising edge and
// compares at every falling edge against a behavioural model. Directed
// reads also check literal values taken from the requirements.
module flash_cmd_if_bench;

    localparam int AW = 11;
    localparam int PC = 6;
    localparam int PM = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lvd_i = 1'b0;
    logic          ce_n = 1'b1;
    logic          oe_n = 1'b1;
    logic          we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    dq_i = '0;
    logic [7:0]    dq_o;
    logic          dq_oe;

    int    n_chk = 0;
    int    n_err = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    flash_cmd_if #(.ADDR_W(AW), .PULSE_CYC(PC), .PULSE_MAX(PM)) u_flash_cmd_if (
        .clk   (clk),
        .rst_n (rst_n),
        .lvd_i (lvd_i),
        .ce_n  (ce_n),
        .oe_n  (oe_n),
        .we_n  (we_n),
        .addr  (addr),
        .dq_i  (dq_i),
        .dq_o  (dq_o),
        .dq_oe (dq_oe)
    );

    // ---------------- behavioural model ----------------
    logic [7:0]    m_mem [1 << AW];
    bit            m_id, m_fail, m_tog, m_pw, m_pr, m_will_fail;
    int            m_seq, m_left;
    logic [AW-1:0] m_lat, m_tgt_a;
    logic [7:0]    m_tgt_d;

    always @(posedge clk) begin
        bit w_now, r_now, w_rise, r_rise, was_busy, was_fail, started;
        if (!rst_n) begin
            for (int i = 0; i < (1 << AW); i++) m_mem[i] = 8'hFF;
            m_id = 0; m_fail = 0; m_tog = 0; m_pw = 1; m_pr = 1;
            m_seq = 0; m_left = 0; m_lat = '0; m_tgt_a = '0; m_tgt_d = '0;
            m_will_fail = 0;
        end else begin
            w_now    = ce_n | we_n;
            r_now    = ce_n | oe_n;
            w_rise   = w_now && !m_pw && oe_n;
            r_rise   = r_now && !m_pr;
            was_busy = (m_left > 0);
            was_fail = m_fail;
            started  = 0;
            if (lvd_i) begin
                m_left = 0; m_fail = 0; m_seq = 0; m_id = 0;
            end else begin
                if (was_busy) begin
                    m_left--;
                    if (m_left == 0) begin
                        m_mem[m_tgt_a] = m_mem[m_tgt_a] & m_tgt_d;
                        m_fail = m_will_fail;
                    end
                end
                if (w_rise && was_fail) begin
                    m_fail = 0; m_seq = 0; m_id = 0;
                end else if (w_rise && !was_busy) begin
                    if (dq_i == 8'hF0) begin
                        m_seq = 0; m_id = 0;
                    end else if (m_seq == 0) begin
                        if (m_lat == 11'h555 && dq_i == 8'hAA) m_seq = 1;
                        else m_id = 0;
                    end else if (m_seq == 1) begin
                        if (m_lat == 11'h2AA && dq_i == 8'h55) m_seq = 2;
                        else begin m_seq = 0; m_id = 0; end
                    end else if (m_seq == 2) begin
                        m_seq = 0;
                        if (m_lat == 11'h555 && dq_i == 8'hA0) m_seq = 3;
                        else if (m_lat == 11'h555 && dq_i == 8'h90) m_id = 1;
                        else m_id = 0;
                    end else begin
                        m_seq = 0; m_id = 0;
                        m_tgt_a = m_lat; m_tgt_d = dq_i;
                        m_will_fail = ((m_mem[m_lat] & dq_i) != dq_i);
                        m_left = m_will_fail ? PC * PM : PC;
                        m_tog = 0; started = 1;
                    end
                end
                if ((was_busy || was_fail) && r_rise && !started) m_tog = ~m_tog;
            end
            if (!w_now && m_pw) m_lat = addr;
            m_pw = w_now;
            m_pr = r_now;
        end
    end

    function automatic logic [7:0] model_byte();
        if (m_left > 0 || m_fail) return {~m_tgt_d[7], m_tog, m_fail, 5'b0};
        if (m_id) begin
            if (addr[7:0] == 8'h00) return 8'h01;
            if (addr[7:0] == 8'h01) return 8'hA4;
            return 8'h00;
        end
        return m_mem[addr];
    endfunction

    // Per-clock comparison with the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_chk++;
            if (dq_oe !== (!ce_n && !oe_n)) begin
                n_err++;
                $display("FAIL %s model dq_oe got %b exp %b", cur_req, dq_oe, !ce_n && !oe_n);
            end
            if (dq_oe) begin
                n_chk++;
                if (dq_o !== model_byte()) begin
                    n_err++;
                    $display("FAIL %s model dq_o got %02h exp %02h", cur_req, dq_o, model_byte());
                end
            end
        end
    end

    // ---------------- tasks ----------------
    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s got %02h exp %02h", tag, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        step();
        addr = a; dq_i = d; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
        step();
        we_n = 1'b1; ce_n = 1'b1;
    endtask

    // Chip-enable-controlled write; address and data change mid-cycle
    task automatic wr_ce(input logic [AW-1:0] a1, input logic [7:0] d1,
                         input logic [AW-1:0] a2, input logic [7:0] d2);
        step();
        addr = a1; dq_i = d1; oe_n = 1'b1; we_n = 1'b0; ce_n = 1'b1;
        step();
        ce_n = 1'b0;
        step();
        addr = a2; dq_i = d2;
        step();
        ce_n = 1'b1;
        step();
        we_n = 1'b1;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [7:0] exp, input string tag);
        step();
        addr = a; ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk);
        chk(tag, dq_o, exp);
        step();
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic prog(input logic [AW-1:0] a, input logic [7:0] d);
        wr(11'h555, 8'hAA);
        wr(11'h2AA, 8'h55);
        wr(11'h555, 8'hA0);
        wr(a, d);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        idle(4);
        @(negedge clk);
        chk("R1 reset dq_oe", {7'd0, dq_oe}, 8'h00);
        step();
        rst_n = 1'b1;
        cur_req = "R1";
        rd(11'h123, 8'hFF, "R1 erased read");

        cur_req = "R2";
        step(); ce_n = 1'b0; oe_n = 1'b1;
        @(negedge clk); chk("R2 oe_n high", {7'd0, dq_oe}, 8'h00);
        step(); oe_n = 1'b0;
        @(negedge clk); chk("R2 both low", {7'd0, dq_oe}, 8'h01);
        step(); ce_n = 1'b1;
        @(negedge clk); chk("R2 standby", {7'd0, dq_oe}, 8'h00);
        step(); oe_n = 1'b1;

        cur_req = "R9";
        prog(11'h010, 8'h5A);
        rd(11'h7FF, 8'h80, "R9 status first read");
        rd(11'h010, 8'hC0, "R9 status toggled");
        idle(PC + 2);
        cur_req = "R4";
        rd(11'h010, 8'h5A, "R4 programmed byte");

        cur_req = "R5";
        prog(11'h010, 8'h4A);
        idle(PC + 2);
        rd(11'h010, 8'h4A, "R5 AND result");

        cur_req = "R6";
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'h90);
        rd(11'h000, 8'h01, "R6 offset 0");
        rd(11'h001, 8'hA4, "R6 offset 1");
        rd(11'h700, 8'h01, "R6 upper bits ignored");
        rd(11'h002, 8'h00, "R6 other offset");
        rd(11'h601, 8'hA4, "R6 mode persists");

        cur_req = "R7";
        wr(11'h3C3, 8'hF0);
        rd(11'h000, 8'hFF, "R7 reset command");
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h56); wr(11'h555, 8'hA0); wr(11'h020, 8'h00);
        idle(PC + 2);
        rd(11'h020, 8'hFF, "R7 broken sequence");
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'h90);
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h11);
        rd(11'h001, 8'hFF, "R7 mismatch leaves id mode");

        cur_req = "R3";
        wr_ce(11'h555, 8'hAA, 11'h555, 8'hAA);
        wr_ce(11'h2AA, 8'h55, 11'h2AA, 8'h55);
        wr_ce(11'h555, 8'hA0, 11'h555, 8'hA0);
        wr_ce(11'h030, 8'hFF, 11'h031, 8'h3C);
        idle(PC + 2);
        rd(11'h030, 8'h3C, "R3 address at fall data at rise");
        rd(11'h031, 8'hFF, "R3 late address unused");

        cur_req = "R8";
        prog(11'h040, 8'h00);
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55);
        idle(PC);
        wr(11'h555, 8'hA0); wr(11'h041, 8'h12);
        idle(PC + 2);
        rd(11'h041, 8'hFF, "R8 writes during busy ignored");
        rd(11'h040, 8'h00, "R8 program completed");

        cur_req = "R12";
        prog(11'h050, 8'h81);
        idle(PC + 2);
        rd(11'h050, 8'h81, "R12 deselected program");

        cur_req = "R10";
        prog(11'h050, 8'h7E);
        rd(11'h050, 8'h80, "R10 busy before timeout");
        idle(PC * PM + 4);
        rd(11'h000, 8'hE0, "R10 timeout flag");
        rd(11'h000, 8'hA0, "R10 status held");
        wr(11'h000, 8'hF0);
        rd(11'h050, 8'h00, "R10 write clears, ANDed byte");

        cur_req = "R11";
        prog(11'h060, 8'h00);
        step(); lvd_i = 1'b1;
        step(); lvd_i = 1'b0;
        rd(11'h060, 8'hFF, "R11 abort before pulse");
        idle(PC + 2);
        rd(11'h060, 8'hFF, "R11 no late program");
        wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'h90);
        step(); lvd_i = 1'b1;
        step(); lvd_i = 1'b0;
        rd(11'h001, 8'hFF, "R11 id mode cleared");

        idle(2);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired in %s", cur_req);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule